// File: doc/BRIEF.md
# Integer ALU Status Flag Generator

This block computes one integer operation on two N-bit operands and the five condition flags (carry, zero, sign, parity, overflow) that a later conditional branch tests. It covers bitwise logic (AND, OR, XOR and a non-writing test), addition, subtraction, a non-writing compare, and increment and decrement by one. The flags are defined through (N+1)-bit arithmetic. Carry is the extra bit of the sum or difference of the zero-extended operands. Overflow is the XOR of the two top bits of the sum or difference of the sign-extended operands.

The datapath is combinational and ends in one output register, so every result and flag appears one clock after its inputs are sampled. A write-enable output tells the register file whether the result should be kept. It is low for the test and compare operations, which only set flags. The incoming carry input carries the current carry flag, because increment and decrement must leave it unchanged.

Top module: `intflag_alu`

## Requirements
- R1: Op codes AND(1), OR(2), XOR(3), ADD(5), SUB(6), INC(7) and DEC(8) raise `we_o`. TEST(0) and CMP(4) hold `we_o` low but still present on `res_o` the value that AND or SUB would give.
- R2: `sf_o` equals bit N-1 of the result.
- R3: `zf_o` is 1 exactly when every result bit is 0.
- R4: `pf_o` is 1 when the number of ones in result bits [7:0] is even (all bits when N < 8).
- R5: For ADD, `cf_o` is 1 when the unsigned sum of the operands is at least 2^N.
- R6: For SUB and CMP, `res_o` is A-B modulo 2^N, and `cf_o` is 1 exactly when unsigned A < unsigned B (a borrow).
- R7: For ADD, SUB, CMP, INC and DEC, `of_o` is 1 exactly when the true signed result does not fit in N-bit two's complement.
- R8: After TEST, AND, OR and XOR, `cf_o` and `of_o` are 0.
- R9: INC and DEC give A+1 and A-1 modulo 2^N with overflow as in R7, and `cf_o` copies `cf_i`.
- R10: Outputs are registered. The values for the inputs present at a rising clock edge appear after that edge. While reset is asserted, every output is 0.
- R11: Op codes 9 to 15 give a zero result, `we_o` low, carry and overflow 0, zero flag 1, parity flag 1 and sign flag 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| op_i | input | 4 | Operation code (see R1, R11) |
| a_i | input | DATA_W | First operand |
| b_i | input | DATA_W | Second operand (ignored by INC and DEC) |
| cf_i | input | 1 | Current carry flag, passed through by INC and DEC |
| res_o | output | DATA_W | Registered result |
| we_o | output | 1 | Result write enable |
| cf_o | output | 1 | Carry flag |
| zf_o | output | 1 | Zero flag |
| sf_o | output | 1 | Sign flag |
| pf_o | output | 1 | Parity flag |
| of_o | output | 1 | Overflow flag |

## Verification
The assertions relate each registered output to the op code and operands sampled on the edge before. They therefore assume that `op_i`, `a_i`, `b_i` and `cf_i` are stable and known at every rising edge after reset, and that `op_i` holds only the codes listed in R1 and R11. The bench changes inputs only on falling edges, so every edge samples a settled value. It drives only known codes, and the unused codes 9 to 15 appear only in the scenario that checks R11.

// File: rtl/intflag_pkg.sv
package intflag_pkg;
  typedef enum logic [3:0] {
    OP_TEST = 4'd0,
    OP_AND  = 4'd1,
    OP_OR   = 4'd2,
    OP_XOR  = 4'd3,
    OP_CMP  = 4'd4,
    OP_ADD  = 4'd5,
    OP_SUB  = 4'd6,
    OP_INC  = 4'd7,
    OP_DEC  = 4'd8
  } op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2
  } lsel_e;

  typedef struct packed {
    logic cf;
    logic zf;
    logic sf;
    logic pf;
    logic of;
  } flags_t;
endpackage

// File: rtl/intflag_rst_sync.sv
module intflag_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/intflag_addsub.sv
module intflag_addsub #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  output logic [DATA_W-1:0] sum,
  output logic              carry,
  output logic              ovf
);
  localparam int EXT_W = DATA_W + 1;

  logic [DATA_W-1:0] b_x;
  logic [EXT_W-1:0]  zext_sum;
  logic [EXT_W-1:0]  sext_sum;

  always_comb begin
    b_x      = sub ? ~b : b;
    zext_sum = {1'b0, a} + {1'b0, b_x} + EXT_W'(sub);
    sext_sum = {a[DATA_W-1], a} + {b_x[DATA_W-1], b_x} + EXT_W'(sub);
    sum      = zext_sum[DATA_W-1:0];
    // Carry-out of A + ~B + 1 is the inverse of a borrow.
    carry    = zext_sum[DATA_W] ^ sub;
    ovf      = sext_sum[DATA_W] ^ sext_sum[DATA_W-1];
  end
endmodule

// File: rtl/intflag_logic.sv
module intflag_logic #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0]  a,
  input  logic [DATA_W-1:0]  b,
  input  intflag_pkg::lsel_e sel,
  output logic [DATA_W-1:0]  y
);
  import intflag_pkg::*;

  always_comb begin
    unique case (sel)
      LG_OR:   y = a | b;
      LG_XOR:  y = a ^ b;
      default: y = a & b;
    endcase
  end
endmodule

// File: rtl/intflag_flags.sv
module intflag_flags #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] res,
  output logic              zf,
  output logic              sf,
  output logic              pf
);
  localparam int PAR_W = (DATA_W < 8) ? DATA_W : 8;

  logic [PAR_W-1:0] par_bits;

  generate
    if (PAR_W == DATA_W) begin : g_par_all
      assign par_bits = res;
    end else begin : g_par_low
      assign par_bits = res[PAR_W-1:0];
    end
  endgenerate

  always_comb begin
    zf = (res == '0);
    sf = res[DATA_W-1];
    pf = ~(^par_bits);
  end
endmodule

// File: rtl/intflag_alu.sv
module intflag_alu #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cf_i,
  output logic [DATA_W-1:0] res_o,
  output logic              we_o,
  output logic              cf_o,
  output logic              zf_o,
  output logic              sf_o,
  output logic              pf_o,
  output logic              of_o
);
  import intflag_pkg::*;

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic              rst_sync_n;
  logic [DATA_W-1:0] as_b;
  logic              as_sub;
  logic [DATA_W-1:0] as_sum;
  logic              as_carry;
  logic              as_ovf;
  lsel_e             lg_sel;
  logic [DATA_W-1:0] lg_y;
  logic [DATA_W-1:0] res_d;
  logic              we_d;
  logic              cf_d;
  logic              of_d;
  logic              zf_d;
  logic              sf_d;
  logic              pf_d;
  logic              load_en;

  intflag_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Operand steering for the shared adder/subtractor.
  always_comb begin
    as_sub = (op_i == OP_SUB) || (op_i == OP_CMP) || (op_i == OP_DEC);
    as_b   = ((op_i == OP_INC) || (op_i == OP_DEC)) ? ONE : b_i;
    unique case (op_i)
      OP_OR:   lg_sel = LG_OR;
      OP_XOR:  lg_sel = LG_XOR;
      default: lg_sel = LG_AND;
    endcase
  end

  intflag_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a     (a_i),
    .b     (as_b),
    .sub   (as_sub),
    .sum   (as_sum),
    .carry (as_carry),
    .ovf   (as_ovf)
  );

  intflag_logic #(.DATA_W(DATA_W)) u_logic (
    .a   (a_i),
    .b   (b_i),
    .sel (lg_sel),
    .y   (lg_y)
  );

  // Next-state selection per operation.
  always_comb begin
    res_d = '0;
    we_d  = 1'b0;
    cf_d  = 1'b0;
    of_d  = 1'b0;
    case (op_i)
      OP_TEST: begin
        res_d = lg_y;
      end
      OP_AND, OP_OR, OP_XOR: begin
        res_d = lg_y;
        we_d  = 1'b1;
      end
      OP_CMP: begin
        res_d = as_sum;
        cf_d  = as_carry;
        of_d  = as_ovf;
      end
      OP_ADD, OP_SUB: begin
        res_d = as_sum;
        we_d  = 1'b1;
        cf_d  = as_carry;
        of_d  = as_ovf;
      end
      OP_INC, OP_DEC: begin
        res_d = as_sum;
        we_d  = 1'b1;
        cf_d  = cf_i;
        of_d  = as_ovf;
      end
      default: begin
        res_d = '0;
      end
    endcase
  end

  intflag_flags #(.DATA_W(DATA_W)) u_flags (
    .res (res_d),
    .zf  (zf_d),
    .sf  (sf_d),
    .pf  (pf_d)
  );

  assign load_en = 1'b1;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_o <= '0;
      we_o  <= 1'b0;
      cf_o  <= 1'b0;
      zf_o  <= 1'b0;
      sf_o  <= 1'b0;
      pf_o  <= 1'b0;
      of_o  <= 1'b0;
    end else if (load_en) begin
      res_o <= res_d;
      we_o  <= we_d;
      cf_o  <= cf_d;
      zf_o  <= zf_d;
      sf_o  <= sf_d;
      pf_o  <= pf_d;
      of_o  <= of_d;
    end
  end
endmodule

// File: rtl/intflag_alu_chk.sv
module intflag_alu_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        op_i,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic              cf_i,
  input logic [DATA_W-1:0] res_o,
  input logic              we_o,
  input logic              cf_o,
  input logic              zf_o,
  input logic              of_o
);
  import intflag_pkg::*;

  logic              seen_q;
  logic [DATA_W-1:0] add_low;
  logic [DATA_W:0]   add_wide;
  logic [DATA_W-1:0] and_val;

  assign add_low  = a_i + b_i;
  assign add_wide = {1'b0, a_i} + {1'b0, b_i};
  assign and_val  = a_i & b_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  AST_NO_WRITE_ON_COMPARE: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && ($past(op_i) == OP_TEST || $past(op_i) == OP_CMP)) |-> !we_o); // R1

  AST_AND_WRITES_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(op_i) == OP_AND) |-> (we_o && res_o == $past(and_val))); // R1

  AST_ZERO_AFTER_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(op_i) == OP_ADD) |-> (zf_o == ($past(add_low) == '0))); // R3

  AST_ADD_CARRY_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(op_i) == OP_ADD) |-> (cf_o == $past(add_wide[DATA_W]))); // R5

  AST_BORROW_IS_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && ($past(op_i) == OP_SUB || $past(op_i) == OP_CMP))
      |-> (cf_o == ($past(a_i) < $past(b_i)))); // R6

  AST_LOGIC_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(op_i) <= OP_XOR) |-> (!cf_o && !of_o)); // R8

  AST_STEP_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && ($past(op_i) == OP_INC || $past(op_i) == OP_DEC))
      |-> (cf_o == $past(cf_i))); // R9
endmodule

bind intflag_alu intflag_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_sync_n),
  .op_i  (op_i),
  .a_i   (a_i),
  .b_i   (b_i),
  .cf_i  (cf_i),
  .res_o (res_o),
  .we_o  (we_o),
  .cf_o  (cf_o),
  .zf_o  (zf_o),
  .of_o  (of_o)
);

// File: tb/intflag_alu_test.sv
`timescale 1ns/1ps
module intflag_alu_test;
  localparam int W = 16;
  localparam longint MODV = longint'(1) << W;
  localparam longint MAXP = (longint'(1) << (W-1)) - 1;
  localparam longint MINN = -(longint'(1) << (W-1));

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [3:0]   op_i = 4'd0;
  logic [W-1:0] a_i = '0;
  logic [W-1:0] b_i = '0;
  logic         cf_i = 1'b0;
  logic [W-1:0] res_o;
  logic we_o, cf_o, zf_o, sf_o, pf_o, of_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  intflag_alu #(.DATA_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i), .cf_i(cf_i),
    .res_o(res_o), .we_o(we_o), .cf_o(cf_o), .zf_o(zf_o), .sf_o(sf_o),
    .pf_o(pf_o), .of_o(of_o)
  );

  function automatic longint sval(input logic [W-1:0] v);
    return v[W-1] ? longint'(v) - MODV : longint'(v);
  endfunction

  // Reference built from the requirement text with wide integers.
  task automatic model(input logic [3:0] op, input logic [W-1:0] a,
                       input logic [W-1:0] b, input logic ci,
                       output logic [W-1:0] r, output logic we,
                       output logic c, output logic o);
    longint t;
    r = '0; we = 1'b0; c = 1'b0; o = 1'b0;
    case (op)
      4'd0: r = a & b;
      4'd1: begin r = a & b; we = 1'b1; end
      4'd2: begin r = a | b; we = 1'b1; end
      4'd3: begin r = a ^ b; we = 1'b1; end
      4'd4, 4'd6: begin
        r = W'(longint'(a) - longint'(b) + MODV);
        c = longint'(a) < longint'(b);
        t = sval(a) - sval(b);
        o = (t > MAXP) || (t < MINN);
        we = (op == 4'd6);
      end
      4'd5: begin
        r = W'(longint'(a) + longint'(b));
        c = (longint'(a) + longint'(b)) >= MODV;
        t = sval(a) + sval(b);
        o = (t > MAXP) || (t < MINN);
        we = 1'b1;
      end
      4'd7, 4'd8: begin
        t = (op == 4'd7) ? 1 : -1;
        r = W'(longint'(a) + t + MODV);
        t = sval(a) + t;
        o = (t > MAXP) || (t < MINN);
        c = ci;
        we = 1'b1;
      end
      default: ;
    endcase
  endtask

  task automatic check(input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Drive on a falling edge, sample one falling edge later (one register).
  task automatic run_vec(input string tag, input logic [3:0] op,
                         input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic ci);
    logic [W-1:0] r; logic we, c, o;
    int ones;
    @(negedge clk);
    op_i = op; a_i = a; b_i = b; cf_i = ci;
    model(op, a, b, ci, r, we, c, o);
    ones = $countones(r[7:0]);
    @(negedge clk);
    checks++;
    if (res_o !== r || we_o !== we || cf_o !== c || of_o !== o ||
        zf_o !== (r == '0) || sf_o !== r[W-1] || pf_o !== (ones % 2 == 0)) begin
      fails++;
      $display("FAIL %s op=%0d a=%h b=%h ci=%b: actual res=%h we=%b c=%b z=%b s=%b p=%b o=%b expected res=%h we=%b c=%b z=%b s=%b p=%b o=%b",
               tag, op, a, b, ci, res_o, we_o, cf_o, zf_o, sf_o, pf_o, of_o,
               r, we, c, (r == '0), r[W-1], (ones % 2 == 0), o);
    end
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    check("R10", "reset outputs", {res_o, we_o, cf_o, zf_o, sf_o, pf_o, of_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic test_latency();
    @(negedge clk);
    op_i = 4'd1; a_i = 16'h00F0; b_i = 16'h0FF0; cf_i = 1'b0;
    @(negedge clk);
    op_i = 4'd2; a_i = 16'h1234;
    #1 check("R10", "value held before edge", res_o, 16'h00F0);
    @(negedge clk);
    check("R10", "value after edge", res_o, 16'h1FF4);
  endtask

  task automatic test_logic();
    run_vec("R1_R8", 4'd0, 16'hFF00, 16'h0F0F, 1'b1);
    run_vec("R1_R8", 4'd1, 16'hFFFF, 16'h8001, 1'b1);
    run_vec("R8_R4", 4'd2, 16'h0000, 16'h0007, 1'b1);
    run_vec("R8_R3", 4'd3, 16'hA5A5, 16'hA5A5, 1'b1);
    run_vec("R2", 4'd2, 16'h8000, 16'h0000, 1'b0);
  endtask

  task automatic test_add();
    run_vec("R5", 4'd5, 16'hFFFF, 16'h0001, 1'b0);
    run_vec("R7", 4'd5, 16'h7FFF, 16'h0001, 1'b0);
    run_vec("R7", 4'd5, 16'h8000, 16'h8000, 1'b0);
    run_vec("R5", 4'd5, 16'h1234, 16'h4321, 1'b1);
  endtask

  task automatic test_sub_cmp();
    run_vec("R6", 4'd6, 16'h0000, 16'h0001, 1'b0);
    run_vec("R6_R3", 4'd4, 16'h5555, 16'h5555, 1'b1);
    run_vec("R7", 4'd6, 16'h8000, 16'h0001, 1'b0);
    run_vec("R1_R6", 4'd4, 16'h0003, 16'hFFFF, 1'b0);
  endtask

  task automatic test_step();
    run_vec("R9", 4'd7, 16'hFFFF, 16'h1234, 1'b0);
    run_vec("R9", 4'd7, 16'h7FFF, 16'h0000, 1'b1);
    run_vec("R9", 4'd8, 16'h0000, 16'hFFFF, 1'b0);
    run_vec("R9", 4'd8, 16'h8000, 16'h0000, 1'b1);
  endtask

  task automatic test_unused();
    for (int c = 9; c < 16; c++)
      run_vec("R11", 4'(c), 16'hFFFF, 16'hFFFF, 1'b1);
  endtask

  task automatic test_corners();
    logic [W-1:0] vals [5] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h8000, 16'h7FFF};
    for (int op = 0; op < 9; op++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          run_vec("R2_R4_R7", 4'(op), vals[i], vals[j], 1'(i ^ j));
  endtask

  task automatic test_random();
    for (int n = 0; n < 400; n++)
      run_vec("R3_R5_R6", 4'($urandom_range(8)), W'($urandom), W'($urandom),
              1'($urandom));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    test_reset();
    test_latency();
    test_logic();
    test_add();
    test_sub_cmp();
    test_step();
    test_unused();
    test_corners();
    test_random();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule